// File: doc/BRIEF.md
# Bus Target Pass-Through Retry Controller

This block sits between a simplified parallel-bus target front end and a local add-on bus. When the bus master starts a cycle, it raises an attention strobe toward the local side. It then waits for the local ready handshake and completes the bus data phase with a one-cycle target-ready pulse. If the local side answers too late, it raises a stop indication instead, so that the master retries the access later. Address decoding, configuration space, parity and the data path itself are handled elsewhere.

Each data phase has a deadline for the local answer. The first phase of a read gets a long window and every later phase gets a short one. Writes land in a two-entry buffer, so the first two write phases are taken at once. Only from the third write phase on can the local side slow the bus down. After a retry, or after the master ends a burst, attention stays up until the local side has finished with the pending data. The burst indicator drops at once, and the direction status stays valid for as long as attention is held. All signals in this description are active-high, and the bus clock and the local clock are one and the same clock.

Top module: `pt_retry_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, every output is 0 after that edge.
- R2: When idle (`loc_attn`=0, `bus_stop`=0) and `bus_frame` is sampled 1 at edge A, `loc_attn` and `loc_burst` are 1 after edge A, and `loc_is_wr` holds the value of `bus_is_wr` sampled at A.
- R3: For a read, `loc_ready` sampled 1 at edge A+k with 1 ≤ k ≤ 15 makes `bus_trdy` 1 for the one cycle after that edge.
- R4: If a read has no `loc_ready` at edges A+1 through A+15, `bus_stop` is 1 after edge A+15 and `bus_trdy` stays 0.
- R5: When a later phase starts at edge E (the edge that accepted the previous phase), the next `loc_ready` is accepted at edges E+2 through E+8. A ready at E+1 is ignored. With no accepted ready, `bus_stop` is 1 after edge E+8.
- R6: For a write, `bus_trdy` is 1 after edge A without any `loc_ready`, and again for the next cycle if `bus_frame` is still 1. Neither phase can raise `bus_stop`. The third phase then follows R5, with E being the second accepting edge.
- R7: In the cycle in which `bus_stop` rises, `loc_burst` is 0, while `loc_attn` and `loc_is_wr` keep their values.
- R8: `bus_stop` and `bus_trdy` are never 1 together. Once raised, `bus_stop` stays 1 while `bus_frame` is 1 and is 0 after the edge that samples `bus_frame` at 0.
- R9: After a read retry, `loc_attn` falls after the edge that samples `loc_ready` = 1, provided that `loc_wr` was sampled 1 at that edge or at an earlier edge since the retry. A ready without a prior local write is ignored.
- R10: After a write retry, both buffer entries are pending. Each sampled `loc_ready` empties one entry, and `loc_attn` falls after the edge that empties the last one.
- R11: If `bus_frame` is sampled 0 during a transfer without a retry, `loc_burst` is 0 after that edge. A read also drops `loc_attn` there. A write keeps `loc_attn` until min(accepted phases, 2) `loc_ready` strobes have been sampled.
- R12: A new access starts only when `loc_attn` and `bus_stop` are both 0. A `bus_frame` seen while either is 1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus and local clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_frame | input | 1 | Master cycle request, held while more data phases follow |
| bus_is_wr | input | 1 | Direction of the requested cycle, 1 = write |
| bus_trdy | output | 1 | Target ready, one cycle per completed data phase |
| bus_stop | output | 1 | Retry request to the master |
| loc_ready | input | 1 | Local ready handshake |
| loc_wr | input | 1 | Local-side write strobe, needed to drain a retried read |
| loc_attn | output | 1 | Attention strobe to the local side |
| loc_burst | output | 1 | Burst in progress on the bus side |
| loc_is_wr | output | 1 | Direction status, valid while attention is held |

## Verification
The arrival of the local ready is swept over every edge of the first read window and one edge beyond it, which separates an on-time answer at the fifteenth edge from a retry one edge later. The same sweep over a later read phase and over the third write phase shows that a ready right after the previous acceptance is ignored, and that the eighth edge is the last one that counts. The retry endings show which local strobes drain attention: a lone ready versus a write followed by a ready for reads, and one versus two readies for writes. Short single-phase writes, a bus frame held during draining and a mid-cycle reset cover the end-of-burst, restart and reset cases.

// File: rtl/ptrc_pkg.sv
package ptrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2
    } xfer_state_e;

    // events from the control FSM to the status registers
    typedef struct packed {
        logic start;
        logic dir_wr;
        logic drop_burst;
        logic retire;
    } stat_evt_t;

    // local-side status as seen on the ports
    typedef struct packed {
        logic attn;
        logic burst;
        logic dir_wr;
    } loc_status_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ptrc_phase_timer.sv
module ptrc_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + TW'(1);
        end
    end

    // the edge sampled with this value is the last one that may carry ready
    assign expire = (cnt == limit - TW'(1));

endmodule

// File: rtl/ptrc_status_regs.sv
module ptrc_status_regs
    import ptrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stat_evt_t   evt,
    output loc_status_t stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (evt.start) begin
            stat.attn   <= 1'b1;
            stat.burst  <= 1'b1;
            stat.dir_wr <= evt.dir_wr;
        end else if (evt.retire) begin
            stat <= '0;
        end else if (evt.drop_burst) begin
            stat.burst <= 1'b0;
        end
    end

endmodule

// File: rtl/ptrc_ctrl.sv
module ptrc_ctrl
    import ptrc_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int OW    = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frame,
    input  logic      is_wr,
    input  logic      loc_ready,
    input  logic      loc_wr,
    input  logic      cur_wr,
    input  logic      t_expire,
    output logic      trdy,
    output logic      stop,
    output logic      t_clr,
    output logic      first_sel,
    output stat_evt_t evt
);
    localparam logic [OW-1:0] DEPTH_V = OW'(DEPTH);

    xfer_state_e   state, state_n;
    logic          trdy_n, stop_n, seen, seen_n;
    logic [OW-1:0] ph, ph_n;   // accepted phases, later the pending write entries

    assign first_sel = (ph == '0);

    always_comb begin
        state_n = state;
        trdy_n  = trdy;
        stop_n  = stop;
        ph_n    = ph;
        seen_n  = seen;
        t_clr   = 1'b0;
        evt     = '0;

        if (stop && !frame) begin
            stop_n = 1'b0;
        end

        case (state)
            ST_IDLE: begin
                if (frame && !stop) begin
                    state_n    = ST_XFER;
                    evt.start  = 1'b1;
                    evt.dir_wr = is_wr;
                    t_clr      = 1'b1;
                    seen_n     = 1'b0;
                    trdy_n     = is_wr;
                    ph_n       = is_wr ? OW'(1) : '0;
                end
            end
            ST_XFER: begin
                if (!frame) begin
                    trdy_n         = 1'b0;
                    evt.drop_burst = 1'b1;
                    if (cur_wr && ph != '0) begin
                        state_n = ST_DRAIN;
                    end else begin
                        state_n    = ST_IDLE;
                        evt.retire = 1'b1;
                    end
                end else if (cur_wr && ph < DEPTH_V) begin
                    trdy_n = 1'b1;           // buffer has room: take it at once
                    ph_n   = ph + OW'(1);
                    t_clr  = 1'b1;
                end else if (trdy) begin
                    trdy_n = 1'b0;
                end else if (loc_ready) begin
                    trdy_n = 1'b1;
                    t_clr  = 1'b1;
                    if (ph < DEPTH_V) begin
                        ph_n = ph + OW'(1);
                    end
                end else if (t_expire) begin
                    stop_n         = 1'b1;
                    evt.drop_burst = 1'b1;
                    state_n        = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (cur_wr) begin
                    if (loc_ready) begin
                        if (ph <= OW'(1)) begin
                            ph_n       = '0;
                            state_n    = ST_IDLE;
                            evt.retire = 1'b1;
                        end else begin
                            ph_n = ph - OW'(1);
                        end
                    end
                end else begin
                    if (loc_wr) begin
                        seen_n = 1'b1;
                    end
                    if (loc_ready && (seen || loc_wr)) begin
                        state_n    = ST_IDLE;
                        evt.retire = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            trdy  <= 1'b0;
            stop  <= 1'b0;
            ph    <= '0;
            seen  <= 1'b0;
        end else begin
            state <= state_n;
            trdy  <= trdy_n;
            stop  <= stop_n;
            ph    <= ph_n;
            seen  <= seen_n;
        end
    end

endmodule

// File: rtl/pt_retry_ctrl.sv
module pt_retry_ctrl
    import ptrc_pkg::*;
#(
    parameter int FIRST_LIMIT  = 15,
    parameter int NEXT_LIMIT   = 8,
    parameter int WR_BUF_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_frame,
    input  logic bus_is_wr,
    output logic bus_trdy,
    output logic bus_stop,
    input  logic loc_ready,
    input  logic loc_wr,
    output logic loc_attn,
    output logic loc_burst,
    output logic loc_is_wr
);
    localparam int MAXL = max_int(FIRST_LIMIT, NEXT_LIMIT);
    localparam int TW   = $clog2(MAXL + 1);
    localparam int OW   = $clog2(WR_BUF_DEPTH + 1);

    stat_evt_t     evt;
    loc_status_t   stat;
    logic          t_clr, t_expire, first_sel;
    logic [TW-1:0] limit;

    assign limit = first_sel ? TW'(FIRST_LIMIT) : TW'(NEXT_LIMIT);

    ptrc_ctrl #(
        .DEPTH (WR_BUF_DEPTH),
        .OW    (OW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frame     (bus_frame),
        .is_wr     (bus_is_wr),
        .loc_ready (loc_ready),
        .loc_wr    (loc_wr),
        .cur_wr    (stat.dir_wr),
        .t_expire  (t_expire),
        .trdy      (bus_trdy),
        .stop      (bus_stop),
        .t_clr     (t_clr),
        .first_sel (first_sel),
        .evt       (evt)
    );

    ptrc_phase_timer #(
        .TW (TW)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (t_clr),
        .limit  (limit),
        .expire (t_expire)
    );

    ptrc_status_regs u_stat (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .stat (stat)
    );

    assign loc_attn  = stat.attn;
    assign loc_burst = stat.burst;
    assign loc_is_wr = stat.dir_wr;

endmodule

// File: rtl/ptrc_checker.sv
module ptrc_checker (
    input logic clk,
    input logic rst,
    input logic bus_frame,
    input logic bus_trdy,
    input logic bus_stop,
    input logic loc_attn,
    input logic loc_burst
);
    assert_trdy_stop_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_trdy && bus_stop));

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && bus_frame) |=> bus_stop);

    assert_stop_drops_burst_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_stop) |-> (!loc_burst && loc_attn));

    assert_trdy_needs_attn_R3: assert property (@(posedge clk) disable iff (rst)
        bus_trdy |-> loc_attn);

    assert_attn_from_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_attn) |-> $past(bus_frame));

    assert_no_start_in_retry_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_attn) |-> !$past(bus_stop));

    assert_burst_needs_attn_R11: assert property (@(posedge clk) disable iff (rst)
        loc_burst |-> loc_attn);

endmodule

bind pt_retry_ctrl ptrc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_frame (bus_frame),
    .bus_trdy  (bus_trdy),
    .bus_stop  (bus_stop),
    .loc_attn  (loc_attn),
    .loc_burst (loc_burst)
);

// File: tb/test_pt_retry_ctrl.sv
`timescale 1ns/1ps
module test_pt_retry_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_frame = 1'b0, bus_is_wr = 1'b0, loc_ready = 1'b0, loc_wr = 1'b0;
    logic bus_trdy, bus_stop, loc_attn, loc_burst, loc_is_wr;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   acc;

    always #4 clk = ~clk;   // 125 MHz

    pt_retry_ctrl i_pt_retry_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_frame (bus_frame),
        .bus_is_wr (bus_is_wr),
        .bus_trdy  (bus_trdy),
        .bus_stop  (bus_stop),
        .loc_ready (loc_ready),
        .loc_wr    (loc_wr),
        .loc_attn  (loc_attn),
        .loc_burst (loc_burst),
        .loc_is_wr (loc_is_wr)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        rst = 1'b1; bus_frame = 1'b0; bus_is_wr = 1'b0; loc_ready = 1'b0; loc_wr = 1'b0;
        tick; tick;
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset;
        chk("R1 attn", loc_attn, 1'b0);
        chk("R1 burst", loc_burst, 1'b0);
        chk("R1 trdy", bus_trdy, 1'b0);
        chk("R1 stop", bus_stop, 1'b0);
        chk("R1 is_wr", loc_is_wr, 1'b0);

        // first read phase: ready at edge A+k, k = 1..16
        for (int k = 1; k <= 16; k++) begin
            do_reset;
            bus_frame = 1'b1; bus_is_wr = 1'b0;
            tick;
            chk("R2 attn", loc_attn, 1'b1);
            chk("R2 burst", loc_burst, 1'b1);
            chk("R2 is_wr", loc_is_wr, 1'b0);
            acc = 1'b0;
            for (int j = 1; j <= 15; j++) begin
                loc_ready = (j == k);
                tick;
                loc_ready = 1'b0;
                if (j == k) begin
                    chk("R3 trdy", bus_trdy, 1'b1);
                    chk("R3 stop", bus_stop, 1'b0);
                    acc = 1'b1;
                    break;
                end else if (j == 15) begin
                    chk("R4 stop", bus_stop, 1'b1);
                    chk("R4 trdy", bus_trdy, 1'b0);
                    chk("R7 burst", loc_burst, 1'b0);
                    chk("R7 attn", loc_attn, 1'b1);
                end else begin
                    chk("R4 early stop", bus_stop, 1'b0);
                    chk("R3 early trdy", bus_trdy, 1'b0);
                end
            end
            if (acc) begin
                bus_frame = 1'b0;
                tick;
                chk("R11 read attn", loc_attn, 1'b0);
                chk("R11 read burst", loc_burst, 1'b0);
                chk("R3 single pulse", bus_trdy, 1'b0);
            end else begin
                tick;
                chk("R8 stop held", bus_stop, 1'b1);
                loc_ready = 1'b1;
                tick;
                loc_ready = 1'b0;
                chk("R9 lone ready ignored", loc_attn, 1'b1);
                loc_wr = 1'b1;
                tick;
                loc_wr = 1'b0;
                chk("R9 attn after write", loc_attn, 1'b1);
                loc_ready = 1'b1;
                tick;
                loc_ready = 1'b0;
                chk("R9 attn drained", loc_attn, 1'b0);
                tick;
                chk("R12 no restart attn", loc_attn, 1'b0);
                chk("R12 stop still", bus_stop, 1'b1);
                bus_frame = 1'b0;
                tick;
                chk("R8 stop cleared", bus_stop, 1'b0);
            end
        end

        // later read phase: ready at edge E+k, k = 1..9
        for (int k = 1; k <= 9; k++) begin
            do_reset;
            bus_frame = 1'b1; bus_is_wr = 1'b0;
            tick;
            loc_ready = 1'b1;
            tick;
            loc_ready = 1'b0;
            chk("R3 phase0 trdy", bus_trdy, 1'b1);
            acc = 1'b0;
            for (int j = 1; j <= 8; j++) begin
                loc_ready = (j == k);
                tick;
                loc_ready = 1'b0;
                if (j == k && k >= 2) begin
                    chk("R5 trdy", bus_trdy, 1'b1);
                    acc = 1'b1;
                    break;
                end else if (j == 8) begin
                    chk("R5 stop", bus_stop, 1'b1);
                    chk("R5 trdy low", bus_trdy, 1'b0);
                end else begin
                    chk("R5 idle trdy", bus_trdy, 1'b0);
                    chk("R5 idle stop", bus_stop, 1'b0);
                end
            end
            bus_frame = 1'b0;
            tick;
            if (acc) begin
                chk("R11 end attn", loc_attn, 1'b0);
            end else begin
                chk("R8 clear", bus_stop, 1'b0);
                chk("R9 attn kept", loc_attn, 1'b1);
                loc_wr = 1'b1; loc_ready = 1'b1;
                tick;
                loc_wr = 1'b0; loc_ready = 1'b0;
                chk("R9 same-edge drain", loc_attn, 1'b0);
            end
        end

        // write burst: third phase ready at edge E+k, k = 1..9
        for (int k = 1; k <= 9; k++) begin
            do_reset;
            bus_frame = 1'b1; bus_is_wr = 1'b1;
            tick;
            chk("R6 phase0 trdy", bus_trdy, 1'b1);
            chk("R2 is_wr", loc_is_wr, 1'b1);
            tick;
            chk("R6 phase1 trdy", bus_trdy, 1'b1);
            chk("R6 phase1 stop", bus_stop, 1'b0);
            acc = 1'b0;
            for (int j = 1; j <= 8; j++) begin
                loc_ready = (j == k);
                tick;
                loc_ready = 1'b0;
                if (j == k && k >= 2) begin
                    chk("R6 phase2 trdy", bus_trdy, 1'b1);
                    acc = 1'b1;
                    break;
                end else if (j == 8) begin
                    chk("R6 phase2 stop", bus_stop, 1'b1);
                    chk("R7 wr burst", loc_burst, 1'b0);
                    chk("R7 wr is_wr", loc_is_wr, 1'b1);
                end else begin
                    chk("R6 wait trdy", bus_trdy, 1'b0);
                    chk("R6 wait stop", bus_stop, 1'b0);
                end
            end
            if (acc) begin
                bus_frame = 1'b0;
                tick;
                chk("R11 wr burst", loc_burst, 1'b0);
                chk("R11 wr attn", loc_attn, 1'b1);
            end
            loc_ready = 1'b1;
            tick;
            loc_ready = 1'b0;
            chk("R10 one left", loc_attn, 1'b1);
            loc_ready = 1'b1;
            tick;
            loc_ready = 1'b0;
            chk("R10 drained", loc_attn, 1'b0);
            bus_frame = 1'b0;
            tick;
            chk("R8 wr stop clear", bus_stop, 1'b0);
        end

        // single-phase write, frame seen during drain, restart, reset mid-cycle
        do_reset;
        bus_frame = 1'b1; bus_is_wr = 1'b1;
        tick;
        bus_frame = 1'b0;
        tick;
        chk("R11 single wr attn", loc_attn, 1'b1);
        chk("R11 single wr burst", loc_burst, 1'b0);
        bus_frame = 1'b1; bus_is_wr = 1'b0;
        tick;
        chk("R12 drain no trdy", bus_trdy, 1'b0);
        chk("R12 drain dir kept", loc_is_wr, 1'b1);
        loc_ready = 1'b1;
        tick;
        loc_ready = 1'b0;
        chk("R11 single wr drained", loc_attn, 1'b0);
        tick;
        chk("R2 restart attn", loc_attn, 1'b1);
        chk("R2 restart dir", loc_is_wr, 1'b0);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        bus_frame = 1'b0;
        chk("R1 mid attn", loc_attn, 1'b0);
        chk("R1 mid burst", loc_burst, 1'b0);
        chk("R1 mid stop", bus_stop, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule